// File: doc/BRIEF.md
# Parallel Port Unlock Sequence Detector

This block sits on the peripheral side of a host parallel port. It watches the eight data lines and the four control lines and looks for a fixed unlock pattern. The host writes the pattern by changing the data lines one byte at a time while control stays at its idle value. A command byte follows the pattern. The host then pulses the control lines to commit the command. The host has no per-byte strobe, so a byte counts as written when the synchronised bus word holds a new value for a set number of clocks.

After the commit pulse, the block reports the command code together with a one-clock valid pulse. It also keeps a linked flag: the connect command sets it and the disconnect command clears it. Every other code is reported but leaves the flag unchanged. An out-of-order word, or a control value that is not idle during the pattern, drops the partial match. A stray 0x22 restarts the match as if it were the first byte of the pattern.

Top module: `pport_unlock_detect`

## Requirements
- R1: After reset, `linked_o` is 0, `cmd_valid_o` is 0 and `cmd_code_o` is 0x00.
- R2: Data and control pass through a two-flop synchroniser. A bus word is taken as written only once it has held for STABLE_CYC (2) consecutive clocks and differs from the last word taken. A one-clock glitch that returns to the same word adds no step.
- R3: The pattern is seven data words taken in this order with control at 0x4: 0x22, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78. Any eighth data word taken with control at 0x4 becomes the command byte.
- R4: After the command byte, control going to 0x5 and then back to 0x4 (data still equal to the command) commits. `cmd_valid_o` is high for exactly one clock, with `cmd_code_o` equal to the command byte.
- R5: Committing command 0xE0 sets `linked_o` to 1.
- R6: Committing command 0x30 clears `linked_o` to 0.
- R7: Committing any other code (for example 0x00 or 0x40) pulses `cmd_valid_o` with that code and leaves `linked_o` unchanged.
- R8: A data word that does not match the expected pattern step drops the partial match. A later strobe then produces no pulse.
- R9: A mismatching word equal to 0x22 with control at 0x4 restarts the match with 0xAA as the next expected word.
- R10: A word taken with control other than 0x4 while the pattern is being matched drops the partial match.
- R11: A control pulse 0x4→0x5→0x4 with no preceding pattern produces no pulse and leaves `linked_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data_i | input | 8 | Host data lines, asynchronous |
| host_ctrl_i | input | 4 | Host control lines, asynchronous (0x4 idle, 0x5 strobe) |
| linked_o | output | 1 | Connected status |
| cmd_code_o | output | 8 | Last committed command code |
| cmd_valid_o | output | 1 | One-clock pulse when a command commits |

## Verification
A wrong matcher step shows up at the ports as a missing or extra `cmd_valid_o` pulse. That pulse is due about seven clocks after the host returns control to idle. A sampler that takes a glitch, or a repeated word, as a new step also breaks a sequence that should commit. A fault in the linked register shows up as a `linked_o` value that does not follow the connect and disconnect history. The scoreboard compares every pulse against the queue of expected codes. Once the bus parks at 0xFF after each sequence, the bench compares `linked_o` against a reference flag.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

    localparam int DATA_W  = 8;
    localparam int CTRL_W  = 4;
    localparam int SEQ_LEN = 7;
    localparam int STEP_W  = $clog2(SEQ_LEN + 1);

    localparam logic [CTRL_W-1:0] CTRL_IDLE   = 4'h4;
    localparam logic [CTRL_W-1:0] CTRL_STROBE = 4'h5;
    localparam logic [DATA_W-1:0] DATA_PARK   = 8'hFF;
    localparam logic [DATA_W-1:0] CMD_LINK    = 8'hE0;
    localparam logic [DATA_W-1:0] CMD_UNLINK  = 8'h30;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } bus_word_t;

    localparam bus_word_t WORD_PARK = '{ctrl: CTRL_IDLE, data: DATA_PARK};

    typedef enum logic [1:0] {
        M_SEQ   = 2'd0,
        M_CMD   = 2'd1,
        M_ARMED = 2'd2,
        M_HIGH  = 2'd3
    } match_st_e;

    function automatic logic [DATA_W-1:0] unlock_byte(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd0:    unlock_byte = 8'h22;
            3'd1:    unlock_byte = 8'hAA;
            3'd2:    unlock_byte = 8'h55;
            3'd3:    unlock_byte = 8'h00;
            3'd4:    unlock_byte = 8'hFF;
            3'd5:    unlock_byte = 8'h87;
            default: unlock_byte = 8'h78;
        endcase
    endfunction

endpackage

// File: rtl/ppu_sync.sv
module ppu_sync
    import ppu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_word_t word_i,
    output bus_word_t word_o
);

    bus_word_t stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        bus_word_t stage_d;
        if (g == 0) begin : g_first
            always_comb stage_d = word_i;
        end else begin : g_next
            always_comb stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= WORD_PARK;
            else        stage_q[g] <= stage_d;
        end
    end

    assign word_o = stage_q[STAGES-1];

endmodule

// File: rtl/ppu_sampler.sv
module ppu_sampler
    import ppu_pkg::*;
#(
    parameter int STABLE_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_word_t word_i,
    output logic      samp_v_o,
    output bus_word_t samp_word_o
);

    localparam int CNT_W = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYC - 1);

    typedef struct packed {
        bus_word_t        cand;
        logic [CNT_W-1:0] cnt;
        bus_word_t        last;
        logic             pulse;
    } samp_st_t;

    samp_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.cand  = word_i;
        if (word_i != st_q.cand) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (word_i == st_q.cand && st_q.cnt == CNT_MAX && st_q.cand != st_q.last) begin
            st_d.last  = st_q.cand;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cand: WORD_PARK, cnt: '0, last: WORD_PARK, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_v_o    = st_q.pulse;
    assign samp_word_o = st_q.last;

    AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        samp_v_o |=> !samp_v_o); // R2
    AST_SAMPLE_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        samp_v_o |-> samp_word_o != $past(samp_word_o)); // R2

endmodule

// File: rtl/ppu_matcher.sv
module ppu_matcher
    import ppu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_v_i,
    input  bus_word_t         samp_word_i,
    output logic              commit_o,
    output logic [DATA_W-1:0] code_o
);

    typedef struct packed {
        match_st_e         st;
        logic [STEP_W-1:0] step;
        logic [DATA_W-1:0] cmd;
        logic              commit;
    } match_t;

    match_t m_d, m_q;

    logic is_idle, is_strobe, is_head;

    always_comb begin
        is_idle   = (samp_word_i.ctrl == CTRL_IDLE);
        is_strobe = (samp_word_i.ctrl == CTRL_STROBE);
        is_head   = is_idle && (samp_word_i.data == unlock_byte('0));

        m_d        = m_q;
        m_d.commit = 1'b0;
        if (samp_v_i) begin
            // default on any mismatch: restart, honouring a fresh head byte
            m_d.st   = M_SEQ;
            m_d.step = is_head ? STEP_W'(1) : '0;
            case (m_q.st)
                M_SEQ: begin
                    if (is_idle && samp_word_i.data == unlock_byte(m_q.step)) begin
                        if (m_q.step == STEP_W'(SEQ_LEN - 1)) begin
                            m_d.st   = M_CMD;
                            m_d.step = '0;
                        end else begin
                            m_d.step = m_q.step + 1'b1;
                        end
                    end
                end
                M_CMD: begin
                    if (is_idle) begin
                        m_d.st   = M_ARMED;
                        m_d.step = '0;
                        m_d.cmd  = samp_word_i.data;
                    end
                end
                M_ARMED: begin
                    if (is_strobe && samp_word_i.data == m_q.cmd) begin
                        m_d.st   = M_HIGH;
                        m_d.step = '0;
                    end
                end
                M_HIGH: begin
                    if (is_idle && samp_word_i.data == m_q.cmd) begin
                        m_d.commit = 1'b1;
                        m_d.step   = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{st: M_SEQ, step: '0, cmd: '0, commit: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign commit_o = m_q.commit;
    assign code_o   = m_q.cmd;

    AST_COMMIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(samp_v_i)); // R4
    AST_COMMIT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(samp_word_i.ctrl) == CTRL_IDLE); // R4

endmodule

// File: rtl/ppu_linkreg.sv
module ppu_linkreg
    import ppu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] code_i,
    output logic              linked_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] code_o
);

    typedef struct packed {
        logic              linked;
        logic              valid;
        logic [DATA_W-1:0] code;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.valid = commit_i;
        if (commit_i) begin
            l_d.code = code_i;
            if (code_i == CMD_LINK)   l_d.linked = 1'b1;
            if (code_i == CMD_UNLINK) l_d.linked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{linked: 1'b0, valid: 1'b0, code: '0};
        else        l_q <= l_d;
    end

    assign linked_o = l_q.linked;
    assign valid_o  = l_q.valid;
    assign code_o   = l_q.code;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R4
    AST_LINK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linked_o) |-> valid_o && code_o == CMD_LINK); // R5
    AST_LINK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(linked_o) |-> valid_o && code_o == CMD_UNLINK); // R6
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(linked_o)); // R7

endmodule

// File: rtl/pport_unlock_detect.sv
module pport_unlock_detect
    import ppu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  host_data_i,
    input  logic [3:0]  host_ctrl_i,
    output logic        linked_o,
    output logic [7:0]  cmd_code_o,
    output logic        cmd_valid_o
);

    bus_word_t         raw_word, sync_word, samp_word;
    logic              samp_v, commit;
    logic [DATA_W-1:0] commit_code;

    assign raw_word = '{ctrl: host_ctrl_i, data: host_data_i};

    ppu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (raw_word),
        .word_o (sync_word)
    );

    ppu_sampler #(.STABLE_CYC(STABLE_CYC)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (sync_word),
        .samp_v_o    (samp_v),
        .samp_word_o (samp_word)
    );

    ppu_matcher u_matcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_v_i    (samp_v),
        .samp_word_i (samp_word),
        .commit_o    (commit),
        .code_o      (commit_code)
    );

    ppu_linkreg u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (commit_code),
        .linked_o (linked_o),
        .valid_o  (cmd_valid_o),
        .code_o   (cmd_code_o)
    );

endmodule

// File: tb/tb_pport_unlock_detect.sv
module tb_pport_unlock_detect;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data_i = 8'hFF;
    logic [3:0] host_ctrl_i = 4'h4;
    logic       linked_o, cmd_valid_o;
    logic [7:0] cmd_code_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit ref_linked = 1'b0;
    string cur_req = "R1";
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    pport_unlock_detect dut (
        .clk(clk), .rst_n(rst_n), .host_data_i(host_data_i), .host_ctrl_i(host_ctrl_i),
        .linked_o(linked_o), .cmd_code_o(cmd_code_o), .cmd_valid_o(cmd_valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pop and compare each committed code
    always @(posedge clk) begin
        #1;
        if (rst_n && cmd_valid_o) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " unexpected pulse"}, cmd_code_o, 'h1FF);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check({cur_req, " code"}, cmd_code_o, e);
            end
        end
    end

    task automatic put(input logic [7:0] d, input logic [3:0] c);
        @(negedge clk);
        host_data_i = d;
        host_ctrl_i = c;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic unlock(input int upto);
        logic [7:0] pat [7] = '{8'h22, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h87, 8'h78};
        for (int i = 0; i < upto; i++) put(pat[i], 4'h4);
    endtask

    task automatic strobe_park(input logic [7:0] cmd);
        put(cmd, 4'h5);
        put(cmd, 4'h4);
        put(8'hFF, 4'h4);
    endtask

    task automatic full_cmd(input string req, input logic [7:0] cmd);
        cur_req = req;
        unlock(7);
        put(cmd, 4'h4);
        exp_q.push_back(cmd);
        if (cmd == 8'hE0) ref_linked = 1'b1;
        if (cmd == 8'h30) ref_linked = 1'b0;
        strobe_park(cmd);
        check({req, " linked"}, linked_o, ref_linked);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 linked", linked_o, 0);
        check("R1 valid", cmd_valid_o, 0);
        check("R1 code", cmd_code_o, 0);
        rst_n = 1'b1;
        repeat (HOLD) @(negedge clk);

        full_cmd("R7", 8'h00);      // plain init code, R3/R4
        full_cmd("R5", 8'hE0);      // connect
        full_cmd("R7", 8'h40);      // config code keeps link

        // R8: wrong third byte, strobe must not commit
        cur_req = "R8";
        put(8'h22, 4'h4); put(8'hAA, 4'h4); put(8'h56, 4'h4);
        put(8'h00, 4'h4); put(8'hFF, 4'h4); put(8'h87, 4'h4); put(8'h78, 4'h4);
        put(8'h30, 4'h4);
        strobe_park(8'h30);
        check("R8 linked unchanged", linked_o, ref_linked);

        // R9: 0x22 mid-pattern restarts at second step
        cur_req = "R9";
        put(8'h22, 4'h4); put(8'hAA, 4'h4); put(8'h55, 4'h4);
        unlock(7);
        put(8'h30, 4'h4);
        exp_q.push_back(8'h30);
        ref_linked = 1'b0;
        strobe_park(8'h30);
        check("R9 linked", linked_o, ref_linked);

        // R11: strobe with no pattern
        cur_req = "R11";
        put(8'hE0, 4'h4);
        strobe_park(8'hE0);
        check("R11 linked", linked_o, ref_linked);

        // R10: control not idle during the pattern
        cur_req = "R10";
        put(8'h22, 4'h4); put(8'hAA, 4'h4); put(8'h55, 4'h6);
        put(8'h00, 4'h4); put(8'hFF, 4'h4); put(8'h87, 4'h4); put(8'h78, 4'h4);
        put(8'hE0, 4'h4);
        strobe_park(8'hE0);
        check("R10 linked", linked_o, ref_linked);

        // R2: one-clock glitch while 0x55 is held
        cur_req = "R2";
        put(8'h22, 4'h4); put(8'hAA, 4'h4);
        @(negedge clk); host_data_i = 8'h55; repeat (4) @(negedge clk);
        host_data_i = 8'h13; @(negedge clk);
        host_data_i = 8'h55; repeat (HOLD) @(negedge clk);
        put(8'h00, 4'h4); put(8'hFF, 4'h4); put(8'h87, 4'h4); put(8'h78, 4'h4);
        put(8'hE0, 4'h4);
        exp_q.push_back(8'hE0);
        ref_linked = 1'b1;
        strobe_park(8'hE0);
        check("R2 linked", linked_o, ref_linked);

        full_cmd("R6", 8'h30);      // disconnect

        repeat (HOLD) @(negedge clk);
        check("R4 pending pulses", exp_q.size(), 0);
        finish_run();
    end

endmodule